// File: doc/BRIEF.md
# Voltage Code Derivation for Lower Load Levels

This block takes the voltage code of the highest-performance load level (level 0) and works out the voltage codes for the three lower load levels. Internally it maps a 6-bit code to a voltage in millivolts. From the level-0 voltage it forms two targets, one 100 mV lower and one 150 mV lower. Each target is raised to a 1000 mV floor when it falls below it. For each target the block then scans the code table upward, one entry per clock, until it finds the first code whose voltage reaches the target.

A single-cycle `start` launches a calculation. `done` pulses once when all three codes are ready. The codes are also delivered pre-formatted as three 32-bit voltage-set words, each carrying the code in both its upper-limit and lower-limit fields. Two control bits are sequenced around the update: the scaling-enable bit drops while the codes are being recomputed and rises again with `done`, and the low-voltage-mode bit is raised with the first valid result. An out-of-range level-0 code is reported through `err` and leaves every other output as it was.

Top module: `avs_level_calc`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `avs_en`, `lowv_en`, the three codes and the three words are all zero.
- R2: Code i (0 to 50) stands for 747 + 35*(i/3) + {0, 11, 23}[i mod 3] mV, which is 747 mV up to 1330 mV. Codes 51 to 63 are out of range.
- R3: An accepted out-of-range `base_code` gives a `done` pulse one cycle after acceptance, with `err` = 1. Codes, words, `avs_en` and `lowv_en` keep their previous values, and `err` stays high until the next accepted start.
- R4: When the level-0 voltage is at or below 1000 mV (codes 0 to 21), all three output codes are 22, the first code at or above 1000 mV.
- R5: Otherwise `code_l1` is the smallest code whose voltage is at or above max(V0 - 100, 1000) mV.
- R6: `code_l2` and `code_l3` are equal. Each is the smallest code whose voltage is at or above max(V0 - 150, 1000) mV.
- R7: Each word `vset_lN` holds `code_lN` in bits [21:16] and again in bits [27:22], with all other bits zero.
- R8: After a valid start, `avs_en` is 0 from the second cycle after acceptance until `done`, and it is 1 with `done`. `lowv_en` becomes 1 with the first valid `done` and stays 1.
- R9: With k1 = `code_l1` and k2 = `code_l2`, a valid calculation raises `done` exactly k1 + k2 + 3 clock edges after the edge that accepts `start`. `done` lasts one cycle, and `busy` is high from acceptance until `done`.
- R10: A `start` while `busy` is high is ignored. The running calculation finishes with its own result and no second `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled when idle |
| base_code | input | 6 | Level-0 voltage code, captured at acceptance |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last accepted level-0 code was out of range |
| code_l1 | output | 6 | Voltage code for load level 1 |
| code_l2 | output | 6 | Voltage code for load level 2 |
| code_l3 | output | 6 | Voltage code for load level 3 |
| vset_l1 | output | 32 | Voltage-set word for level 1 |
| vset_l2 | output | 32 | Voltage-set word for level 2 |
| vset_l3 | output | 32 | Voltage-set word for level 3 |
| avs_en | output | 1 | Voltage-scaling enable, low while codes are recomputed |
| lowv_en | output | 1 | Low-voltage-mode enable |

## Verification
The properties assume that reset is asserted before the first `start`. They also assume that `base_code` matters only at the cycle where `start` is accepted, so a value that changes while `busy` is high has no effect on the outcome. The stimulus mixes in-range and out-of-range codes drawn uniformly over all 64 values. It scrambles `base_code` right after each acceptance, and it deliberately fires a second `start` with a different code in the middle of a long calculation. Because every valid target lies well below the top table voltage, the fall-back to the last entry cannot be reached with the default parameters, and no check depends on it.

// File: rtl/avs_calc_pkg.sv
package avs_calc_pkg;

   // number of derived load levels (level 0 is the input)
   localparam int NUM_LVL = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_SRCH  = 2'd2
   } calc_state_t;

endpackage

// File: rtl/avs_mv_table.sv
// Code-to-millivolt mapping: mv = BASE_MV + floor(STEP_NUM*code/STEP_DEN).
// USE_ROM selects a constant lookup array or direct arithmetic.
module avs_mv_table #(
   parameter int CODE_W    = 6,
   parameter int MV_W      = 11,
   parameter int NUM_CODES = 51,
   parameter int BASE_MV   = 747,
   parameter int STEP_NUM  = 35,
   parameter int STEP_DEN  = 3,
   parameter bit USE_ROM   = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output logic [MV_W-1:0]   mv
);

   localparam int PROD_W = MV_W + CODE_W;
   localparam logic [CODE_W-1:0] LAST = CODE_W'(NUM_CODES - 1);

   logic [CODE_W-1:0] sel;

   // out-of-range codes read the top entry
   assign sel = (code > LAST) ? LAST : code;

   generate
      if (USE_ROM) begin : g_rom
         logic [MV_W-1:0] rom [NUM_CODES];
         for (genvar g = 0; g < NUM_CODES; g++) begin : g_fill
            assign rom[g] = MV_W'(BASE_MV + (STEP_NUM * g) / STEP_DEN);
         end
         assign mv = rom[sel];
      end else begin : g_arith
         logic [PROD_W-1:0] prod;
         logic [PROD_W-1:0] quot;
         assign prod = PROD_W'(STEP_NUM) * PROD_W'(sel);
         assign quot = prod / PROD_W'(STEP_DEN);
         assign mv   = MV_W'(BASE_MV) + MV_W'(quot);
      end
   endgenerate

endmodule

// File: rtl/avs_target_gen.sv
// Forms the two clamped millivolt targets from the level-0 voltage.
module avs_target_gen #(
   parameter int MV_W     = 11,
   parameter int FLOOR_MV = 1000,
   parameter int OFF_NEAR = 100,
   parameter int OFF_FAR  = 150
) (
   input  logic [MV_W-1:0] base_mv,
   output logic            low_mode,
   output logic [MV_W-1:0] tgt_near,
   output logic [MV_W-1:0] tgt_far
);

   localparam logic [MV_W-1:0] FLOOR = MV_W'(FLOOR_MV);

   logic [MV_W-1:0] near_raw;
   logic [MV_W-1:0] far_raw;

   // the subtraction is taken only when it cannot go under the floor
   assign near_raw = (base_mv < MV_W'(FLOOR_MV + OFF_NEAR)) ? FLOOR
                                                           : base_mv - MV_W'(OFF_NEAR);
   assign far_raw  = (base_mv < MV_W'(FLOOR_MV + OFF_FAR))  ? FLOOR
                                                           : base_mv - MV_W'(OFF_FAR);

   assign low_mode = (base_mv <= FLOOR);
   assign tgt_near = low_mode ? FLOOR : near_raw;
   assign tgt_far  = low_mode ? FLOOR : far_raw;

endmodule

// File: rtl/avs_roundup_search.sv
// Walks the table upward one entry per cycle until the entry reaches the target.
module avs_roundup_search #(
   parameter int CODE_W    = 6,
   parameter int MV_W      = 11,
   parameter int NUM_CODES = 51,
   parameter int BASE_MV   = 747,
   parameter int STEP_NUM  = 35,
   parameter int STEP_DEN  = 3,
   parameter bit USE_ROM   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              active,
   input  logic [MV_W-1:0]   target,
   output logic              hit,
   output logic [CODE_W-1:0] code
);

   localparam logic [CODE_W-1:0] LAST = CODE_W'(NUM_CODES - 1);

   logic [CODE_W-1:0] idx_q;
   logic [MV_W-1:0]   idx_mv;
   logic              at_last;

   avs_mv_table #(
      .CODE_W(CODE_W), .MV_W(MV_W), .NUM_CODES(NUM_CODES),
      .BASE_MV(BASE_MV), .STEP_NUM(STEP_NUM), .STEP_DEN(STEP_DEN),
      .USE_ROM(USE_ROM)
   ) u_tab (
      .code (idx_q),
      .mv   (idx_mv)
   );

   assign at_last = (idx_q == LAST);
   // no qualifying entry: settle on the top entry
   assign hit     = active && ((idx_mv >= target) || at_last);
   assign code    = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (restart) begin
         idx_q <= '0;
      end else if (active && !hit) begin
         idx_q <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/avs_vset_pack.sv
// Places one code in both limit fields of a voltage-set word.
module avs_vset_pack #(
   parameter int WORD_W = 32,
   parameter int CODE_W = 6,
   parameter int HI_LSB = 16,
   parameter int LO_LSB = 22
) (
   input  logic [CODE_W-1:0] code,
   output logic [WORD_W-1:0] word
);

   always_comb begin
      word = '0;
      word[HI_LSB +: CODE_W] = code;
      word[LO_LSB +: CODE_W] = code;
   end

endmodule

// File: rtl/avs_level_calc.sv
module avs_level_calc
   import avs_calc_pkg::*;
#(
   parameter int CODE_W    = 6,
   parameter int MV_W      = 11,
   parameter int NUM_CODES = 51,
   parameter int BASE_MV   = 747,
   parameter int STEP_NUM  = 35,
   parameter int STEP_DEN  = 3,
   parameter int FLOOR_MV  = 1000,
   parameter int OFF_NEAR  = 100,
   parameter int OFF_FAR   = 150,
   parameter int WORD_W    = 32,
   parameter int HI_LSB    = 16,
   parameter int LO_LSB    = 22,
   parameter bit USE_ROM   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] base_code,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [CODE_W-1:0] code_l1,
   output logic [CODE_W-1:0] code_l2,
   output logic [CODE_W-1:0] code_l3,
   output logic [WORD_W-1:0] vset_l1,
   output logic [WORD_W-1:0] vset_l2,
   output logic [WORD_W-1:0] vset_l3,
   output logic              avs_en,
   output logic              lowv_en
);

   localparam int TOP_MV = BASE_MV + (STEP_NUM * (NUM_CODES - 1)) / STEP_DEN;

   // elaboration-time parameter checks
   generate
      if (NUM_CODES < 2 || NUM_CODES > (1 << CODE_W)) begin : g_bad_codes
         $error("NUM_CODES must fit in CODE_W bits");
      end
      if (TOP_MV >= (1 << MV_W) || (FLOOR_MV + OFF_FAR) >= (1 << MV_W)) begin : g_bad_mv
         $error("MV_W too narrow for the voltage range");
      end
      if (STEP_DEN < 1) begin : g_bad_den
         $error("STEP_DEN must be positive");
      end
      if (HI_LSB + CODE_W > LO_LSB || LO_LSB + CODE_W > WORD_W) begin : g_bad_fields
         $error("limit fields overlap or exceed the word");
      end
      if (OFF_FAR < OFF_NEAR) begin : g_bad_off
         $error("far offset must not be below near offset");
      end
   endgenerate

   calc_state_t       state_q;
   logic [CODE_W-1:0] base_q;
   logic [MV_W-1:0]   base_mv;
   logic              base_ok;
   logic              low_mode;
   logic [MV_W-1:0]   tgt_near;
   logic [MV_W-1:0]   tgt_far;
   logic [MV_W-1:0]   tgt_near_q;
   logic [MV_W-1:0]   tgt_far_q;
   logic              lvl_q;
   logic              srch_restart;
   logic              srch_active;
   logic              srch_hit;
   logic [MV_W-1:0]   srch_target;
   logic [CODE_W-1:0] srch_code;
   logic              done_q;
   logic              err_q;
   logic              avs_en_q;
   logic              lowv_q;
   logic [CODE_W-1:0] code_q [NUM_LVL];
   logic [WORD_W-1:0] word_w [NUM_LVL];

   // level-0 voltage lookup
   avs_mv_table #(
      .CODE_W(CODE_W), .MV_W(MV_W), .NUM_CODES(NUM_CODES),
      .BASE_MV(BASE_MV), .STEP_NUM(STEP_NUM), .STEP_DEN(STEP_DEN),
      .USE_ROM(USE_ROM)
   ) u_base_tab (
      .code (base_q),
      .mv   (base_mv)
   );

   avs_target_gen #(
      .MV_W(MV_W), .FLOOR_MV(FLOOR_MV),
      .OFF_NEAR(OFF_NEAR), .OFF_FAR(OFF_FAR)
   ) u_tgt (
      .base_mv  (base_mv),
      .low_mode (low_mode),
      .tgt_near (tgt_near),
      .tgt_far  (tgt_far)
   );

   assign base_ok      = ({1'b0, base_q} < (CODE_W+1)'(NUM_CODES));
   assign srch_active  = (state_q == ST_SRCH);
   assign srch_restart = (state_q == ST_CHECK) || (srch_hit && !lvl_q);
   assign srch_target  = lvl_q ? tgt_far_q : tgt_near_q;

   avs_roundup_search #(
      .CODE_W(CODE_W), .MV_W(MV_W), .NUM_CODES(NUM_CODES),
      .BASE_MV(BASE_MV), .STEP_NUM(STEP_NUM), .STEP_DEN(STEP_DEN),
      .USE_ROM(USE_ROM)
   ) u_srch (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (srch_restart),
      .active  (srch_active),
      .target  (srch_target),
      .hit     (srch_hit),
      .code    (srch_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         base_q     <= '0;
         tgt_near_q <= '0;
         tgt_far_q  <= '0;
         lvl_q      <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
         avs_en_q   <= 1'b0;
         lowv_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  base_q  <= base_code;
                  err_q   <= 1'b0;
                  state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (!base_ok) begin
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  // low_mode already folds both targets onto the floor
                  tgt_near_q <= low_mode ? MV_W'(FLOOR_MV) : tgt_near;
                  tgt_far_q  <= tgt_far;
                  lvl_q      <= 1'b0;
                  avs_en_q   <= 1'b0;
                  state_q    <= ST_SRCH;
               end
            end
            ST_SRCH: begin
               if (srch_hit) begin
                  if (!lvl_q) begin
                     lvl_q <= 1'b1;
                  end else begin
                     done_q   <= 1'b1;
                     avs_en_q <= 1'b1;
                     lowv_q   <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // result registers: level 1 from the near search, levels 2.. from the far search
   generate
      for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
         logic load;
         if (g == 0) begin : g_near
            assign load = srch_hit && !lvl_q;
         end else begin : g_far
            assign load = srch_hit && lvl_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code_q[g] <= '0;
            end else if (load) begin
               code_q[g] <= srch_code;
            end
         end

         avs_vset_pack #(
            .WORD_W(WORD_W), .CODE_W(CODE_W),
            .HI_LSB(HI_LSB), .LO_LSB(LO_LSB)
         ) u_pack (
            .code (code_q[g]),
            .word (word_w[g])
         );
      end
   endgenerate

   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign err     = err_q;
   assign avs_en  = avs_en_q;
   assign lowv_en = lowv_q;
   assign code_l1 = code_q[0];
   assign code_l2 = code_q[1];
   assign code_l3 = code_q[2];
   assign vset_l1 = word_w[0];
   assign vset_l2 = word_w[1];
   assign vset_l3 = word_w[2];

endmodule

// File: rtl/avs_level_calc_chk.sv
module avs_level_calc_chk #(
   parameter int CODE_W = 6,
   parameter int WORD_W = 32,
   parameter int HI_LSB = 16,
   parameter int LO_LSB = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [CODE_W-1:0] code_l1,
   input logic [CODE_W-1:0] code_l2,
   input logic [WORD_W-1:0] vset_l1,
   input logic              avs_en,
   input logic              lowv_en
);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10
   busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R8
   avs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !avs_en);

   // R8
   lowv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lowv_en) |-> lowv_en);

   // R6
   code_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (code_l1 >= code_l2));

   // R3
   err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> ($stable(code_l1) && $stable(code_l2)));

   // R7
   field_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vset_l1[HI_LSB +: CODE_W] == code_l1) && (vset_l1[LO_LSB +: CODE_W] == code_l1));

endmodule

bind avs_level_calc avs_level_calc_chk #(
   .CODE_W(CODE_W), .WORD_W(WORD_W), .HI_LSB(HI_LSB), .LO_LSB(LO_LSB)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .err     (err),
   .code_l1 (code_l1),
   .code_l2 (code_l2),
   .vset_l1 (vset_l1),
   .avs_en  (avs_en),
   .lowv_en (lowv_en)
);

// File: tb/test_avs_level_calc.sv
`timescale 1ns/1ps
module test_avs_level_calc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  base_code = '0;
   logic        busy, done, err, avs_en, lowv_en;
   logic [5:0]  code_l1, code_l2, code_l3;
   logic [31:0] vset_l1, vset_l2, vset_l3;

   int checks = 0;
   int fails  = 0;

   logic [5:0] exp1 = '0, exp2 = '0;
   logic       exp_avs = 1'b0, exp_lowv = 1'b0;

   always #2.5 clk = ~clk;

   avs_level_calc i_avs_level_calc (
      .clk(clk), .rst_n(rst_n), .start(start), .base_code(base_code),
      .busy(busy), .done(done), .err(err),
      .code_l1(code_l1), .code_l2(code_l2), .code_l3(code_l3),
      .vset_l1(vset_l1), .vset_l2(vset_l2), .vset_l3(vset_l3),
      .avs_en(avs_en), .lowv_en(lowv_en)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // R2: table voltage of a code
   function automatic int ref_mv(input int i);
      int frac;
      case (i % 3)
         0: frac = 0;
         1: frac = 11;
         default: frac = 23;
      endcase
      return 747 + 35 * (i / 3) + frac;
   endfunction

   function automatic int ref_code(input int target);
      for (int i = 0; i <= 50; i++) begin
         if (ref_mv(i) >= target) return i;
      end
      return 50;
   endfunction

   function automatic logic [31:0] ref_word(input logic [5:0] c);
      return (32'(c) << 16) | (32'(c) << 22);
   endfunction

   task automatic run_one(input logic [5:0] code, input bit inject);
      int  v0, t1, t2, lat, cnt;
      bit  valid, seen;
      valid = (code < 6'd51);
      if (valid) begin
         v0 = ref_mv(int'(code));
         t1 = v0 - 100;
         t2 = v0 - 150;
         if (v0 <= 1000) begin t1 = 1000; t2 = 1000; end
         if (t1 < 1000) t1 = 1000;
         if (t2 < 1000) t2 = 1000;
         exp1 = 6'(ref_code(t1));
         exp2 = 6'(ref_code(t2));
         lat  = int'(exp1) + int'(exp2) + 3;
      end else begin
         lat = 1;
      end
      @(negedge clk);
      start = 1'b1;
      base_code = code;
      @(negedge clk);
      start = 1'b0;
      base_code = 6'($urandom % 64);
      cnt = 0;
      seen = 1'b0;
      while (!seen && cnt < 400) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (inject && cnt == 4) begin
            start = 1'b1;
            base_code = 6'd0;
         end else if (inject && cnt == 5) begin
            start = 1'b0;
         end
         if (valid && cnt == 1)
            chk(avs_en == 1'b0, "R8 enable dropped", avs_en, 0);
         if (done) seen = 1'b1;
         else chk(busy == 1'b1, "R9 busy during run", busy, 1);
      end
      start = 1'b0;
      chk(seen, "R9 done seen", seen, 1);
      chk(cnt == lat, valid ? "R9 latency" : "R3 latency", cnt, lat);
      chk(err == !valid, "R3 err flag", err, !valid);
      if (valid) begin
         exp_avs  = 1'b1;
         exp_lowv = 1'b1;
      end
      chk(code_l1 == exp1, code < 6'd22 ? "R4 code_l1" : "R5 code_l1", code_l1, exp1);
      chk(code_l2 == exp2, code < 6'd22 ? "R4 code_l2" : "R6 code_l2", code_l2, exp2);
      chk(code_l3 == exp2, code < 6'd22 ? "R4 code_l3" : "R6 code_l3", code_l3, exp2);
      chk(vset_l1 == ref_word(exp1), "R7 vset_l1", vset_l1, ref_word(exp1));
      chk(vset_l2 == ref_word(exp2), "R7 vset_l2", vset_l2, ref_word(exp2));
      chk(vset_l3 == ref_word(exp2), "R7 vset_l3", vset_l3, ref_word(exp2));
      chk(avs_en == exp_avs, "R8 avs_en at done", avs_en, exp_avs);
      chk(lowv_en == exp_lowv, "R8 lowv_en at done", lowv_en, exp_lowv);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", done, 0);
      chk(err == !valid, "R3 err held", err, !valid);
   endtask

   initial begin
      int seed_dummy, extra;
      seed_dummy = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk({busy, done, err, avs_en, lowv_en} == 5'b0, "R1 flags", {busy, done, err, avs_en, lowv_en}, 0);
      chk({code_l1, code_l2, code_l3} == 18'b0, "R1 codes", {code_l1, code_l2, code_l3}, 0);
      chk((vset_l1 | vset_l2 | vset_l3) == 32'b0, "R1 words", vset_l1 | vset_l2 | vset_l3, 0);

      // R3: out-of-range first, nothing else may move
      run_one(6'd51, 1'b0);
      run_one(6'd63, 1'b0);
      // R4 corners and R5/R6 top of range
      run_one(6'd0,  1'b0);
      run_one(6'd21, 1'b0);
      run_one(6'd22, 1'b0);
      run_one(6'd50, 1'b0);
      run_one(6'd60, 1'b0);
      run_one(6'd35, 1'b0);
      // R10: second start mid-run
      run_one(6'd50, 1'b1);
      extra = 0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (done || busy) extra++;
      end
      chk(extra == 0, "R10 no second run", extra, 0);
      chk(code_l1 == exp1, "R10 result kept", code_l1, exp1);

      for (int n = 0; n < 60; n++) begin
         run_one(6'($urandom % 64), 1'b0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule